// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves bytes over a three-wire synchronous link: a shift clock, a data output and a data input. The transmitter and the receiver share one shift clock. A host loads a byte into a transmit holding register, and the block copies it into a shift register. The block then drives the byte out least-significant bit first while it samples the input line into a receive shift register. Each completed byte lands in a receive holding register.

The shift clock is produced internally by a prescaler (divide by 1 or by 4), a reload divider (divide by n+1) and a toggle stage that halves the result. As an alternative, the block follows an external clock supplied on `sclk_i`. The output changes on falling shift-clock edges and the input is sampled on rising edges. The clock rests high between transfers. A byte written while another is still shifting follows it with no break in the clock.

The host sees four byte-wide locations: data at 0, status at 1, control at 2 and divider reload at 3. Status bit 0 is transmit buffer empty, bit 1 is shift complete, bit 2 is receive buffer full and bit 3 is overrun. Control bit 0 is mode enable, bit 1 is external clock, bit 2 is prescale by 4, bit 3 selects the transmit interrupt source and bit 4 is receive enable.

Top module: `sync_sio`

## Requirements
- R1: After reset the status location reads 0x03 (bit0 buffer empty, bit1 shift complete, bit2 receive full clear, bit3 overrun clear). `txd` and `sclk_o` are high, and `tx_irq`, `rx_irq` and `rdy_o` are low.
- R2: While control bit0 is 0, a write to location 0 starts no transfer: `sclk_o` makes no edge, and status reads 0x02 with bit0 clear. Setting control bit0 later starts the pending byte.
- R3: With control bit1 = 0, each half-period of `sclk_o` lasts (n+1)*P clock cycles. Here n is the value at location 3, and P is 4 when control bit2 = 1 and 1 otherwise. `sclk_o` is high whenever no transfer is running.
- R4: Each byte produces exactly eight falling edges of the shift clock. `txd` changes only just after a falling edge, and bits leave in the order D0 first, D7 last.
- R5: `rxd` is sampled on each rising shift-clock edge and assembled D0 first. The completed byte is readable at location 0 and sets status bit2. A read of location 0 clears bit2.
- R6: With control bit1 = 1, shifting follows the synchronized edges of `sclk_i`, and `sclk_o` stays high.
- R7: A byte written while a shift is in progress follows the current byte with no gap in the shift clock. Status bit1 stays 0 until the last chained byte ends.
- R8: Control bit3 = 0 makes `tx_irq` pulse for one cycle each time the transmit buffer empties. Control bit3 = 1 makes it pulse once when shifting ends.
- R9: `rx_irq` pulses for one cycle whenever status bit2 goes from 0 to 1.
- R10: A byte completing while status bit2 is 1 sets status bit3, and the new byte replaces the buffer contents. Any write to location 1 clears bit3.
- R11: `rdy_o` is high only while control bit0 and control bit4 (receive enable) are 1 and status bit2 is 0. With bit4 = 0, a completed byte is discarded and bit2 stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (side effects only) |
| addr | input | 2 | Location select: 0 data, 1 status, 2 control, 3 divider |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the selected location |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Internally generated shift clock, idles high |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| rdy_o | output | 1 | Ready to receive |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The divider is swept over several reload values and both prescale settings, up to the slowest setting. Measuring the falling-edge spacing separates an off-by-one in the reload from a missing halving stage. Data patterns cover all-zero, all-one, single-bit and mixed bytes, sent through a loopback. This separates a reversed bit order from a correct one, which a loopback alone would hide. Two chained bytes are sent under each interrupt-source setting: the pulse counts (two against one) show which flag feeds `tx_irq`, and the edge span shows whether a gap was inserted. Runs with the mode off, with receive disabled and with the external clock show that those settings block or reroute the shifting as specified.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int PRE_W  = 2;   // slow count source divides by 2**PRE_W

  localparam logic [1:0] LOC_DATA = 2'd0;
  localparam logic [1:0] LOC_STAT = 2'd1;
  localparam logic [1:0] LOC_CTRL = 2'd2;
  localparam logic [1:0] LOC_DIV  = 2'd3;

  // control location, bit4 down to bit0
  typedef struct packed {
    logic rx_en;       // bit4
    logic ti_on_done;  // bit3
    logic pre_slow;    // bit2
    logic clk_ext;     // bit1
    logic mode_en;     // bit0
  } ctrl_t;
endpackage

// File: rtl/sio_baud_gen.sv
`timescale 1ns/1ps
module sio_baud_gen #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_tick;

  function automatic logic [DIV_W-1:0] wrap_inc(input logic [DIV_W-1:0] c,
                                                input logic [DIV_W-1:0] lim);
    return (c >= lim) ? '0 : c + 1'b1;
  endfunction

  assign pre_tick = slow ? (&pre_cnt) : 1'b1;
  assign tick     = run && pre_tick && (div_cnt >= reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      if (pre_tick) div_cnt <= wrap_inc(div_cnt, reload);
    end
  end

  // R3: back-to-back ticks only at the fastest setting
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick && $past(tick) && $past(run) && $stable(reload) && $stable(slow)
      |-> (reload == '0) && !slow);
endmodule

// File: rtl/sio_clk_sel.sv
`timescale 1ns/1ps
module sio_clk_sel #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic use_ext,
  input  logic tick,
  input  logic sclk_i,
  output logic sclk_o,
  output logic fall_ev,
  output logic rise_ev
);
  logic [SYNC_N-1:0] sync_q;
  logic              ext_prev;
  logic              sclk_q;
  logic              ext_now, ext_fall, ext_rise, int_fall, int_rise;

  assign ext_now = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      ext_prev <= 1'b1;
      sclk_q   <= 1'b1;
    end else begin
      sync_q   <= {sync_q[SYNC_N-2:0], sclk_i};
      ext_prev <= ext_now;
      if (!run || use_ext) sclk_q <= 1'b1;
      else if (tick)       sclk_q <= ~sclk_q;
    end
  end

  assign ext_fall = ext_prev & ~ext_now;
  assign ext_rise = ~ext_prev & ext_now;
  assign int_fall = tick & sclk_q;
  assign int_rise = tick & ~sclk_q;

  assign fall_ev = run & (use_ext ? ext_fall : int_fall);
  assign rise_ev = run & (use_ext ? ext_rise : int_rise);
  assign sclk_o  = sclk_q;

  // R6: internal clock stays parked while the external one is selected
  a_r6_ext_parks_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    use_ext && $past(use_ext) |-> sclk_o);
endmodule

// File: rtl/sio_shifter.sv
`timescale 1ns/1ps
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              rxd,
  output logic              txd,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [CNT_W-1:0]  cnt;
  logic              txd_q;

  assign byte_done = rise_ev && (cnt == CNT_W'(DATA_W - 1));
  assign rx_byte   = {rxd, rx_sh[DATA_W-1:1]};
  assign txd       = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      cnt   <= '0;
      txd_q <= 1'b1;
    end else begin
      if (fall_ev) txd_q <= tx_sh[0];
      if (rise_ev) begin
        rx_sh <= rx_byte;
        tx_sh <= tx_sh >> 1;
        cnt   <= byte_done ? '0 : cnt + 1'b1;
      end
      if (load) begin
        tx_sh <= load_data;
        cnt   <= '0;
      end
    end
  end

  // R4: the data line moves only after a falling shift edge
  a_r4_txd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(fall_ev));
  // R4: bit counter restarts after each byte
  a_r4_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (cnt == '0));
endmodule

// File: rtl/sync_sio.sv
`timescale 1ns/1ps
module sync_sio
  import sio_pkg::*;
#(
  parameter int DATA_W = sio_pkg::DATA_W,
  parameter int DIV_W  = sio_pkg::DIV_W,
  parameter int PRE_W  = sio_pkg::PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              txd,
  input  logic              rxd,
  output logic              rdy_o,
  output logic              tx_irq,
  output logic              rx_irq
);
  ctrl_t             ctrl;
  logic [DIV_W-1:0]  reload;
  logic [DATA_W-1:0] tbuf, rbuf, rx_byte;
  logic              tbe, tsc, rbf, ovr, busy;
  logic              tbe_d, tsc_d, rbf_d;
  logic              tick, fall_ev, rise_ev, byte_done;
  logic              wr_data, wr_stat, wr_ctrl, wr_div, rd_data;
  logic              start, chain, finish, load, rx_take;

  assign wr_data = wr_en && (addr == LOC_DATA);
  assign wr_stat = wr_en && (addr == LOC_STAT);
  assign wr_ctrl = wr_en && (addr == LOC_CTRL);
  assign wr_div  = wr_en && (addr == LOC_DIV);
  assign rd_data = rd_en && (addr == LOC_DATA);

  assign start   = ctrl.mode_en && !busy && !tbe;
  assign chain   = byte_done && !tbe;
  assign finish  = byte_done && tbe;
  assign load    = start || chain;
  assign rx_take = byte_done && ctrl.rx_en;

  sio_baud_gen #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy && !ctrl.clk_ext),
    .slow(ctrl.pre_slow), .reload(reload), .tick(tick));

  sio_clk_sel #(.SYNC_N(2)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .use_ext(ctrl.clk_ext),
    .tick(tick), .sclk_i(sclk_i), .sclk_o(sclk_o),
    .fall_ev(fall_ev), .rise_ev(rise_ev));

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(tbuf),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .rxd(rxd), .txd(txd),
    .byte_done(byte_done), .rx_byte(rx_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
      tbuf   <= '0;
      rbuf   <= '0;
      tbe    <= 1'b1;
      tsc    <= 1'b1;
      rbf    <= 1'b0;
      ovr    <= 1'b0;
      busy   <= 1'b0;
      tbe_d  <= 1'b1;
      tsc_d  <= 1'b1;
      rbf_d  <= 1'b0;
    end else begin
      tbe_d <= tbe;
      tsc_d <= tsc;
      rbf_d <= rbf;
      if (wr_ctrl) ctrl   <= ctrl_t'(wdata[4:0]);
      if (wr_div)  reload <= wdata[DIV_W-1:0];
      if (wr_data) begin
        tbuf <= wdata;
        tbe  <= 1'b0;
      end else if (load) begin
        tbe  <= 1'b1;
      end
      if (start) begin
        busy <= 1'b1;
        tsc  <= 1'b0;
      end else if (finish) begin
        busy <= 1'b0;
        tsc  <= 1'b1;
      end
      if (rx_take) begin
        rbuf <= rx_byte;
        rbf  <= 1'b1;
      end else if (rd_data) begin
        rbf  <= 1'b0;
      end
      if (rx_take && rbf) ovr <= 1'b1;
      else if (wr_stat)   ovr <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      LOC_DATA: rdata = rbuf;
      LOC_STAT: rdata = DATA_W'({ovr, rbf, tsc, tbe});
      LOC_CTRL: rdata = DATA_W'(ctrl);
      default:  rdata = DATA_W'(reload);
    endcase
  end

  assign rdy_o  = ctrl.mode_en & ctrl.rx_en & ~rbf;
  assign tx_irq = ctrl.ti_on_done ? (tsc & ~tsc_d) : (tbe & ~tbe_d);
  assign rx_irq = rbf & ~rbf_d;

  // R3: shift clock rests high outside a transfer
  a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);
  // R7: shift-complete flag stays low for the whole chained run
  a_r7_tsc_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tsc);
  // R8: transmit interrupt is a single-cycle pulse
  a_r8_tx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
  // R9: receive interrupt follows a completed byte
  a_r9_rx_irq_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(byte_done));
  // R10: overrun only when a byte lands on a full buffer
  a_r10_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rbf) && $past(byte_done));
  // R11: ready drops once a received byte is taken
  a_r11_rdy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> !rdy_o);
endmodule

// File: tb/sync_sio_tb.sv
`timescale 1ns/1ps
module sync_sio_tb;
  import sio_pkg::*;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;
  logic       sclk_i = 1'b1;
  wire        sclk_o, txd, rdy_o, tx_irq, rx_irq;
  logic       ext_mon = 1'b0;
  wire        rxd = txd;   // loopback

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sync_sio u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk_i(sclk_i), .sclk_o(sclk_o),
    .txd(txd), .rxd(rxd), .rdy_o(rdy_o), .tx_irq(tx_irq), .rx_irq(rx_irq));

  // edge and pulse monitor, sampled away from the active edge
  int         fall_cnt = 0, txirq_n = 0, rxirq_n = 0;
  int         fall_cyc [64];
  logic [7:0] cap = 8'd0;
  logic       mon_prev = 1'b1;
  wire        mon_clk = ext_mon ? sclk_i : sclk_o;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_prev && !mon_clk) begin
      fall_cyc[fall_cnt % 64] = cyc;
      fall_cnt = fall_cnt + 1;
    end
    if (!mon_prev && mon_clk) cap = {txd, cap[7:1]};
    mon_prev = mon_clk;
    if (tx_irq) txirq_n = txirq_n + 1;
    if (rx_irq) rxirq_n = rxirq_n + 1;
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    int n;
    @(negedge clk); @(negedge clk);
    s = 8'd0; n = 0;
    while (!s[1] && n < 30000) begin
      rd(LOC_STAT, s);
      n++;
    end
    if (!s[1]) chk("R7 transfer end", 0, 1);
  endtask

  // one byte over the internal clock with loopback; h = half period in cycles
  task automatic xfer(input logic [7:0] d, input int h, input string tag);
    logic [7:0] s;
    int f0, r0;
    f0 = fall_cnt; r0 = rxirq_n;
    wr(LOC_DATA, d);
    wait_done();
    chk({tag, " R4 falls per byte"}, fall_cnt - f0, 8);
    chk({tag, " R4 bit order D0 first"}, cap, d);
    chk({tag, " R3 full period"}, fall_cyc[(f0+1)%64] - fall_cyc[f0%64], 2*h);
    chk({tag, " R3 span of eight falls"}, fall_cyc[(f0+7)%64] - fall_cyc[f0%64], 14*h);
    rd(LOC_STAT, s);
    chk({tag, " R5 status full"}, s, 8'h07);
    chk({tag, " R11 rdy low when full"}, rdy_o, 0);
    chk({tag, " R9 rx pulse count"}, rxirq_n - r0, 1);
    rd(LOC_DATA, s);
    chk({tag, " R5 received byte"}, s, d);
    rd(LOC_STAT, s);
    chk({tag, " R5 read clears full"}, s, 8'h03);
    chk({tag, " R11 rdy back"}, rdy_o, 1);
  endtask

  task automatic chained(input logic sel_done, input int exp_tx);
    logic [7:0] s;
    int f0, t0, r0;
    wr(LOC_DIV, 8'd1);
    wr(LOC_CTRL, sel_done ? 8'h19 : 8'h11);
    f0 = fall_cnt; t0 = txirq_n; r0 = rxirq_n;
    wr(LOC_DATA, 8'h6B);
    wr(LOC_DATA, 8'hD2);
    rd(LOC_STAT, s);
    chk("R7 mid-shift flags low", s[1:0], 0);
    wait_done();
    chk("R7 sixteen falls", fall_cnt - f0, 16);
    chk("R7 no gap between bytes", fall_cyc[(f0+15)%64] - fall_cyc[f0%64], 30*2);
    chk("R7 second byte on line", cap, 8'hD2);
    chk("R8 tx pulses for source", txirq_n - t0, exp_tx);
    chk("R9 single rx pulse", rxirq_n - r0, 1);
    rd(LOC_STAT, s);
    chk("R10 overrun set", s, 8'h0F);
    wr(LOC_STAT, 8'h00);
    rd(LOC_STAT, s);
    chk("R10 overrun cleared", s, 8'h07);
    rd(LOC_DATA, s);
    chk("R10 newest byte kept", s, 8'hD2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 190000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int f0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(LOC_STAT, s);
    chk("R1 status", s, 8'h03);
    chk("R1 txd high", txd, 1);
    chk("R1 sclk high", sclk_o, 1);
    chk("R1 irqs low", tx_irq | rx_irq, 0);
    chk("R1 rdy low", rdy_o, 0);

    // R2 mode off holds the byte
    wr(LOC_CTRL, 8'h10);
    chk("R11 rdy low with mode off", rdy_o, 0);
    f0 = fall_cnt;
    wr(LOC_DATA, 8'h96);
    repeat (50) @(negedge clk);
    chk("R2 no shift clock", fall_cnt - f0, 0);
    rd(LOC_STAT, s);
    chk("R2 buffer held", s, 8'h02);
    wr(LOC_CTRL, 8'h11);
    wait_done();
    chk("R2 pending byte sent", cap, 8'h96);
    rd(LOC_DATA, s);
    chk("R2 pending byte received", s, 8'h96);

    // data pattern sweep at the fastest clock
    for (int i = 0; i < 18; i++) begin
      logic [7:0] d;
      d = (i < 16) ? 8'(i * 17) : ((i == 16) ? 8'h01 : 8'h80);
      xfer(d, 1, $sformatf("pattern %0d", i));
    end

    // divider and prescale sweep
    for (int sl = 0; sl < 2; sl++) begin
      for (int k = 0; k < 5; k++) begin
        int n;
        n = (k == 4) ? 6 : k;
        wr(LOC_DIV, 8'(n));
        wr(LOC_CTRL, sl ? 8'h15 : 8'h11);
        xfer(8'(n * 29 + sl * 101 + 7), (n + 1) * (sl ? 4 : 1),
             $sformatf("div %0d slow %0d", n, sl));
      end
    end
    wr(LOC_DIV, 8'd255);
    wr(LOC_CTRL, 8'h15);
    xfer(8'hA5, 256 * 4, "slowest");

    // R8 / R7 / R10 chained bytes under both interrupt sources
    chained(1'b0, 2);
    chained(1'b1, 1);

    // R11 receive disabled discards the byte
    wr(LOC_DIV, 8'd0);
    wr(LOC_CTRL, 8'h01);
    chk("R11 rdy low when rx off", rdy_o, 0);
    r0 = rxirq_n;
    wr(LOC_DATA, 8'hC3);
    wait_done();
    rd(LOC_STAT, s);
    chk("R11 byte discarded", s, 8'h03);
    chk("R11 no rx pulse", rxirq_n - r0, 0);

    // R6 external clock
    ext_mon = 1'b1;
    wr(LOC_CTRL, 8'h13);
    wr(LOC_DATA, 8'h3C);
    repeat (4) @(negedge clk);
    chk("R6 sclk_o parked", sclk_o, 1);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); #1 sclk_i = 1'b0;
      repeat (6) @(negedge clk);
      #1 sclk_i = 1'b1;
      repeat (6) @(negedge clk);
      if (sclk_o != 1'b1) chk("R6 sclk_o stays high", sclk_o, 1);
    end
    repeat (6) @(negedge clk);
    ext_mon = 1'b0;
    chk("R6 line order", cap, 8'h3C);
    rd(LOC_STAT, s);
    chk("R6 byte complete", s, 8'h07);
    rd(LOC_DATA, s);
    chk("R6 received byte", s, 8'h3C);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule